// File: doc/BRIEF.md
# SPI Master with Programmable Frame Timing

This block is a single-lane SPI master for leading-edge capture (clock phase 0). A command with a data word, a frame length, a bit-order choice and a select-hold flag is accepted through a valid/ready handshake. Each command becomes one frame on the serial pins. While a frame runs, the received word is built up. At the end of the frame it is offered with a one-cycle strobe. The clock polarity and four timing counts are static configuration inputs, all measured in system clocks: the serial half-period, the select-to-first-edge lead, the last-edge-to-release trail, and the minimum released gap.

A controller with five states sequences each frame. IDLE waits for a command (IDLE to LEAD on accept). LEAD holds select low for the lead count and emits serial edge 1 when it expires (LEAD to SHIFT). SHIFT emits one edge each half-period and ends on edge 2N (SHIFT to TRAIL). TRAIL waits out the trail count. When it expires, it either re-enters LEAD with select still low, if the frame asked to hold select and a new command is offered (TRAIL to LEAD), or it releases select (TRAIL to GAP). GAP holds select high for the gap count (GAP to IDLE).

Odd-numbered serial edges sample the input line. Even-numbered edges, apart from the last, advance the output line. A completion pulse marks edge 2N-1.

Top module: `spim_master`

## Requirements
- R1: After reset, spi_cs_n is 1, cmd_ready is 1, rx_valid and xfer_done are 0, and spi_sck equals cfg_cpol.
- R2: When a command is accepted, spi_cs_n falls on the next clock edge, and spi_sout already carries the first data bit. The first spi_sck transition comes exactly cfg_csc clocks after spi_cs_n falls.
- R3: A frame of N bits (cmd_bits, 2 to DATA_W) gives exactly 2N spi_sck transitions, spaced exactly cfg_half clocks apart.
- R4: spi_sin is sampled on odd-numbered transitions (1, 3, ...). spi_sout changes only at even-numbered transitions, never at the last one, so it is stable at every odd transition.
- R5: With cmd_lsb_first = 0, bit N-1 is sent and received first. With cmd_lsb_first = 1, bit 0 goes first. The rule applies to both directions. Data bits at N and above are never sent, and rx_data bits at N and above read 0.
- R6: spi_sck rests at cfg_cpol whenever select is released. Edge numbering does not depend on polarity.
- R7: rx_valid is high for exactly one clock, starting at the clock edge that produces transition 2N, and rx_data then holds the received word.
- R8: xfer_done is high for exactly one clock, starting at the clock edge that produces transition 2N-1.
- R9: spi_cs_n rises exactly cfg_asc clocks after transition 2N, unless the frame is chained as in R11.
- R10: After spi_cs_n rises, it stays high for at least cfg_dt+1 clocks. If a command is already waiting, it falls again exactly cfg_dt+1 clocks after the rise.
- R11: If a frame was issued with cmd_hold_cs = 1 and another command is valid when its trail count ends, spi_cs_n stays low. The first transition of the next frame then follows the last transition of the previous frame by exactly cfg_asc+cfg_csc clocks.
- R12: If cmd_hold_cs = 1 but no command is waiting when the trail count ends, select is released as in R9.
- R13: cmd_ready is 0 while a frame is in LEAD or SHIFT, and no command is taken then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cpol | input | 1 | Serial clock resting level |
| cfg_half | input | CNT_W | Serial half-period in clocks, at least 1 |
| cfg_csc | input | CNT_W | Select-to-first-edge lead in clocks, at least 1 |
| cfg_asc | input | CNT_W | Last-edge-to-release trail in clocks, at least 1 |
| cfg_dt | input | CNT_W | Minimum released gap in clocks, at least 1 |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken when high with cmd_valid |
| cmd_data | input | DATA_W | Word to transmit |
| cmd_bits | input | LEN_W | Frame length in bits, 2 to DATA_W |
| cmd_lsb_first | input | 1 | 1 = bit 0 first, 0 = top bit first |
| cmd_hold_cs | input | 1 | Keep select low into a waiting next frame |
| rx_valid | output | 1 | Received word strobe |
| rx_data | output | DATA_W | Received word, zero above the frame length |
| xfer_done | output | 1 | Completion pulse at transition 2N-1 |
| spi_sck | output | 1 | Serial clock |
| spi_sout | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sin | input | 1 | Serial data in |

## Verification
The assertions assume that every timing count is at least 1 and that cmd_bits lies between 2 and DATA_W. They also assume that the configuration inputs do not change while select is low. Under those assumptions the serial clock can never toggle with select released and never comes to rest off its idle level. The stimulus changes configuration only when the bench has seen select high and the controller back in IDLE, and every table entry and directed case uses counts and lengths inside those bounds. The bench's slave model changes spi_sin only after even transitions or at the select fall, so the input is settled whenever the master samples it.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_SHIFT = 3'd2,
        ST_TRAIL = 3'd3,
        ST_GAP   = 3'd4
    } spim_state_t;

endpackage

// File: rtl/spim_shift.sv
module spim_shift #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic              cap,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [LEN_W-1:0]  cmd_bits,
    input  logic              cmd_lsb_first,
    input  logic              sin,
    output logic              sout,
    output logic [DATA_W-1:0] rx_word
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [DATA_W-1:0] tx_q;
    logic [IDX_W-1:0]  idx_q;
    logic              lsb_q;
    logic [IDX_W-1:0]  first_idx;
    logic [IDX_W-1:0]  next_idx;

    // The first bit is bit 0 or bit N-1, depending on the order.
    always_comb begin
        first_idx = cmd_lsb_first ? '0 : IDX_W'(cmd_bits - 1'b1);
        next_idx  = lsb_q ? (idx_q + 1'b1) : (idx_q - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q    <= '0;
            idx_q   <= '0;
            lsb_q   <= 1'b0;
            sout    <= 1'b0;
            rx_word <= '0;
        end else if (load) begin
            tx_q    <= cmd_data;
            idx_q   <= first_idx;
            lsb_q   <= cmd_lsb_first;
            sout    <= cmd_data[first_idx];
            rx_word <= '0;
        end else begin
            // A received bit takes the weight of the bit sent alongside it.
            if (cap) begin
                rx_word[idx_q] <= sin;
            end
            if (adv) begin
                idx_q <= next_idx;
                sout  <= tx_q[next_idx];
            end
        end
    end

    // R4: the output line moves only on a load or an even transition.
    a_r4_sout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(sout));

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int LEN_W = 5,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_half,
    input  logic [CNT_W-1:0] cfg_csc,
    input  logic [CNT_W-1:0] cfg_asc,
    input  logic [CNT_W-1:0] cfg_dt,
    input  logic             cmd_valid,
    input  logic [LEN_W-1:0] cmd_bits,
    input  logic             cmd_hold_cs,
    output logic             cmd_ready,
    output logic             load,
    output logic             adv,
    output logic             cap,
    output logic             cs_n,
    output logic             phase,
    output logic             xfer_done,
    output logic             rx_valid
);
    localparam int EDGE_W = LEN_W + 1;

    spim_state_t       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [EDGE_W-1:0] edge_q;
    logic [LEN_W-1:0]  bits_q;
    logic              hold_q;

    logic              tick;
    logic              accept;
    logic              edge_now;
    logic              last_edge;
    logic              early_edge;
    logic [EDGE_W-1:0] edge_idx;
    logic [EDGE_W-1:0] edge_total;

    always_comb begin
        tick       = (cnt_q == '0);
        cmd_ready  = (state_q == ST_IDLE) ||
                     ((state_q == ST_TRAIL) && tick && hold_q);
        accept     = cmd_valid && cmd_ready;
        edge_now   = tick && ((state_q == ST_LEAD) || (state_q == ST_SHIFT));
        edge_idx   = edge_q + 1'b1;
        edge_total = {bits_q, 1'b0};
        last_edge  = edge_now && (edge_idx == edge_total);
        early_edge = edge_now && (edge_idx == (edge_total - 1'b1));
        load       = accept;
        cap        = edge_now && edge_idx[0];
        adv        = edge_now && !edge_idx[0] && !last_edge;
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)    state_d = ST_LEAD;
            ST_LEAD:  if (tick)      state_d = ST_SHIFT;
            ST_SHIFT: if (last_edge) state_d = ST_TRAIL;
            ST_TRAIL: if (tick)      state_d = accept ? ST_LEAD : ST_GAP;
            ST_GAP:   if (tick)      state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // State register with its interval counter and edge count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            edge_q  <= '0;
            bits_q  <= LEN_W'(2);
            hold_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q  <= cfg_csc - 1'b1;
                edge_q <= '0;
                bits_q <= cmd_bits;
                hold_q <= cmd_hold_cs;
            end else if (edge_now) begin
                edge_q <= edge_idx;
                cnt_q  <= last_edge ? (cfg_asc - 1'b1) : (cfg_half - 1'b1);
            end else if ((state_q == ST_TRAIL) && tick) begin
                cnt_q <= cfg_dt - 1'b1;
            end else if (!tick) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Registered pin-side outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n      <= 1'b1;
            phase     <= 1'b0;
            xfer_done <= 1'b0;
            rx_valid  <= 1'b0;
        end else begin
            xfer_done <= early_edge;
            rx_valid  <= last_edge;
            if (edge_now) begin
                phase <= ~phase;
            end
            if (accept) begin
                cs_n <= 1'b0;
            end else if ((state_q == ST_TRAIL) && tick) begin
                cs_n <= 1'b1;
            end
        end
    end

    // R2: the serial clock moves only while select is asserted.
    a_r2_sck_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(phase) |-> !cs_n);

    // R6: with select released, the clock sits at its resting level.
    a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !phase);

    // R8: completion is a single-cycle pulse.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R7: the received word is offered while select is still low.
    a_r7_rxv_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !cs_n);

    // R10: a release lasts beyond the clock edge that causes it.
    a_r10_gap_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);

    // R13: no command is taken during the lead or shift phases.
    a_r13_busy_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LEAD) || (state_q == ST_SHIFT)) |-> !cmd_ready);

endmodule

// File: rtl/spim_master.sv
module spim_master #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = $clog2(DATA_W + 1),
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic [CNT_W-1:0]  cfg_half,
    input  logic [CNT_W-1:0]  cfg_csc,
    input  logic [CNT_W-1:0]  cfg_asc,
    input  logic [CNT_W-1:0]  cfg_dt,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [LEN_W-1:0]  cmd_bits,
    input  logic              cmd_lsb_first,
    input  logic              cmd_hold_cs,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              xfer_done,
    output logic              spi_sck,
    output logic              spi_sout,
    output logic              spi_cs_n,
    input  logic              spi_sin
);
    logic load, adv, cap, phase;

    spim_ctrl #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_half    (cfg_half),
        .cfg_csc     (cfg_csc),
        .cfg_asc     (cfg_asc),
        .cfg_dt      (cfg_dt),
        .cmd_valid   (cmd_valid),
        .cmd_bits    (cmd_bits),
        .cmd_hold_cs (cmd_hold_cs),
        .cmd_ready   (cmd_ready),
        .load        (load),
        .adv         (adv),
        .cap         (cap),
        .cs_n        (spi_cs_n),
        .phase       (phase),
        .xfer_done   (xfer_done),
        .rx_valid    (rx_valid)
    );

    spim_shift #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (load),
        .adv           (adv),
        .cap           (cap),
        .cmd_data      (cmd_data),
        .cmd_bits      (cmd_bits),
        .cmd_lsb_first (cmd_lsb_first),
        .sin           (spi_sin),
        .sout          (spi_sout),
        .rx_word       (rx_data)
    );

    assign spi_sck = cfg_cpol ^ phase;

endmodule

// File: tb/spim_master_tb.sv
module spim_master_tb;
    localparam int DW = 16;
    localparam int LW = 5;
    localparam int CW = 8;

    typedef struct packed {
        logic [15:0] d;
        logic [15:0] s;
        logic [4:0]  n;
        logic        lsb;
        logic        cpol;
        logic [7:0]  half;
        logic [7:0]  csc;
        logic [7:0]  asc;
        logic [7:0]  dt;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'h00A5, 16'h003C, 5'd8,  1'b0, 1'b0, 8'd1, 8'd1, 8'd1, 8'd1},
        '{16'h00A5, 16'h003C, 5'd8,  1'b1, 1'b1, 8'd2, 8'd3, 8'd2, 8'd2},
        '{16'hBEEF, 16'h1234, 5'd16, 1'b0, 1'b1, 8'd3, 8'd2, 8'd4, 8'd3},
        '{16'hEABC, 16'hF555, 5'd13, 1'b1, 1'b0, 8'd1, 8'd5, 8'd1, 8'd1},
        '{16'hFFF2, 16'hFFF1, 5'd2,  1'b0, 1'b0, 8'd4, 8'd1, 8'd3, 8'd5},
        '{16'hFFFF, 16'h0000, 5'd16, 1'b1, 1'b0, 8'd1, 8'd1, 8'd1, 8'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_cpol = 1'b0;
    logic [CW-1:0] cfg_half = 8'd1, cfg_csc = 8'd1, cfg_asc = 8'd1, cfg_dt = 8'd1;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [DW-1:0] cmd_data = '0;
    logic [LW-1:0] cmd_bits = 5'd8;
    logic cmd_lsb_first = 1'b0;
    logic cmd_hold_cs = 1'b0;
    logic rx_valid;
    logic [DW-1:0] rx_data;
    logic xfer_done, spi_sck, spi_sout, spi_cs_n;
    logic spi_sin = 1'b0;

    spim_master #(.DATA_W(DW), .LEN_W(LW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_half(cfg_half),
        .cfg_csc(cfg_csc), .cfg_asc(cfg_asc), .cfg_dt(cfg_dt),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .cmd_bits(cmd_bits), .cmd_lsb_first(cmd_lsb_first), .cmd_hold_cs(cmd_hold_cs),
        .rx_valid(rx_valid), .rx_data(rx_data), .xfer_done(xfer_done),
        .spi_sck(spi_sck), .spi_sout(spi_sout), .spi_cs_n(spi_cs_n), .spi_sin(spi_sin)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pin monitor and slave model
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int mbits = 8;
    bit mlsb = 1'b0;
    logic [DW-1:0] slv [2];
    logic [DW-1:0] mosi [2];
    int edge_t [64];
    int n_edges, n_fall, n_rise, n_done, n_rxv;
    int fall_t [4];
    int rise_t [4];
    int done_t;
    int rxv_t [2];
    logic [DW-1:0] rx_got [2];
    logic prev_sck = 1'b0;
    logic prev_cs = 1'b1;

    function automatic int bitpos(input int j);
        return mlsb ? j : (mbits - 1 - j);
    endfunction

    task automatic arm();
        n_edges = 0; n_fall = 0; n_rise = 0; n_done = 0; n_rxv = 0;
        mosi[0] = '0; mosi[1] = '0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !spi_cs_n) begin
                if (n_fall < 4) fall_t[n_fall] = cyc;
                n_fall++;
                spi_sin = slv[(n_edges / (2 * mbits)) % 2][bitpos(0)];
            end
            if (!prev_cs && spi_cs_n) begin
                if (n_rise < 4) rise_t[n_rise] = cyc;
                n_rise++;
            end
            if (!spi_cs_n && (spi_sck != prev_sck)) begin
                int k, fr, j;
                if (n_edges < 64) edge_t[n_edges] = cyc;
                n_edges++;
                k  = ((n_edges - 1) % (2 * mbits)) + 1;
                fr = ((n_edges - 1) / (2 * mbits)) % 2;
                j  = (k - 1) / 2;
                if (k % 2 == 1) begin
                    mosi[fr][bitpos(j)] = spi_sout;
                end else if (k < 2 * mbits) begin
                    spi_sin = slv[fr][bitpos(j + 1)];
                end else begin
                    spi_sin = slv[(fr + 1) % 2][bitpos(0)];
                end
            end
            if (xfer_done) begin
                done_t = cyc;
                n_done++;
            end
            if (rx_valid) begin
                if (n_rxv < 2) begin
                    rxv_t[n_rxv]  = cyc;
                    rx_got[n_rxv] = rx_data;
                end
                n_rxv++;
            end
        end
        prev_sck = spi_sck;
        prev_cs  = spi_cs_n;
    end

    task automatic drive(input logic [15:0] d, input int n, input bit lsb, input bit hold);
        cmd_data = d;
        cmd_bits = LW'(n);
        cmd_lsb_first = lsb;
        cmd_hold_cs = hold;
        cmd_valid = 1'b1;
        mbits = n;
        mlsb = lsb;
    endtask

    task automatic wait_accept();
        int g = 0;
        while (!cmd_ready && g < 5000) begin
            @(negedge clk);
            g++;
        end
        @(negedge clk);
    endtask

    task automatic wait_idle(input int rises);
        int g = 0;
        while (!(n_rise >= rises && cmd_ready && spi_cs_n) && g < 5000) begin
            @(negedge clk);
            g++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic set_cfg(input vec_t v);
        cfg_cpol = v.cpol; cfg_half = v.half; cfg_csc = v.csc;
        cfg_asc = v.asc; cfg_dt = v.dt;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, checked under both polarities
        cfg_cpol = 1'b1;
        repeat (3) @(negedge clk);
        chk(spi_sck == 1'b1, "R1 sck rest cpol=1 in reset", int'(spi_sck), 1);
        cfg_cpol = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1 cs_n", int'(spi_cs_n), 1);
        chk(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
        chk(rx_valid == 1'b0 && xfer_done == 1'b0, "R1 strobes",
            int'({rx_valid, xfer_done}), 0);
        chk(spi_sck == 1'b0, "R1 sck rest cpol=0", int'(spi_sck), 0);

        // Table of single frames: R2 R3 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            int n, msk, bad;
            n = int'(VECS[v].n);
            msk = (1 << n) - 1;
            set_cfg(VECS[v]);
            slv[0] = VECS[v].s; slv[1] = VECS[v].s;
            @(negedge clk);
            arm();
            drive(VECS[v].d, n, VECS[v].lsb, 1'b0);
            wait_accept();
            cmd_valid = 1'b0;
            wait_idle(1);
            chk(int'(mosi[0]) == (int'(VECS[v].d) & msk), "R4 R5 sent word",
                int'(mosi[0]), int'(VECS[v].d) & msk);
            chk(int'(rx_got[0]) == (int'(VECS[v].s) & msk), "R5 received word",
                int'(rx_got[0]), int'(VECS[v].s) & msk);
            chk(n_edges == 2 * n, "R3 edge count", n_edges, 2 * n);
            bad = 0;
            for (int e = 1; e < 2 * n; e++)
                if (edge_t[e] - edge_t[e-1] != int'(VECS[v].half)) bad++;
            chk(bad == 0, "R3 edge spacing", bad, 0);
            chk(edge_t[0] - fall_t[0] == int'(VECS[v].csc), "R2 lead",
                edge_t[0] - fall_t[0], int'(VECS[v].csc));
            chk(n_done == 1 && done_t == edge_t[2*n-2], "R8 done at edge 2N-1",
                done_t - edge_t[2*n-2], 0);
            chk(n_rxv == 1 && rxv_t[0] == edge_t[2*n-1], "R7 rx_valid at edge 2N",
                rxv_t[0] - edge_t[2*n-1], 0);
            chk(rise_t[0] - edge_t[2*n-1] == int'(VECS[v].asc), "R9 trail",
                rise_t[0] - edge_t[2*n-1], int'(VECS[v].asc));
            chk(spi_sck == VECS[v].cpol, "R6 rest level", int'(spi_sck), int'(VECS[v].cpol));
        end

        // R10 and R13: second command waiting during a frame, select not held
        cfg_cpol = 1'b0; cfg_half = 8'd2; cfg_csc = 8'd2; cfg_asc = 8'd2; cfg_dt = 8'd4;
        slv[0] = 16'h005A; slv[1] = 16'h00C3;
        @(negedge clk);
        arm();
        drive(16'h0081, 8, 1'b0, 1'b0);
        wait_accept();
        drive(16'h0042, 8, 1'b0, 1'b0);
        while (n_edges < 3) @(negedge clk);
        chk(cmd_ready == 1'b0, "R13 ready low mid-frame", int'(cmd_ready), 0);
        chk(n_fall == 1, "R13 no second accept", n_fall, 1);
        wait_accept();
        cmd_valid = 1'b0;
        wait_idle(2);
        chk(fall_t[1] - rise_t[0] == 5, "R10 gap dt+1", fall_t[1] - rise_t[0], 5);
        chk(int'(mosi[1]) == 16'h0042, "R10 second word sent", int'(mosi[1]), 16'h0042);

        // R11: chained frames with select held
        cfg_half = 8'd1; cfg_csc = 8'd3; cfg_asc = 8'd2; cfg_dt = 8'd1;
        slv[0] = 16'h00F0; slv[1] = 16'h0033;
        @(negedge clk);
        arm();
        drive(16'h0096, 8, 1'b1, 1'b1);
        wait_accept();
        drive(16'h0069, 8, 1'b1, 1'b0);
        wait_accept();
        cmd_valid = 1'b0;
        wait_idle(1);
        chk(n_fall == 1 && n_rise == 1, "R11 select held", n_fall + n_rise, 2);
        chk(edge_t[16] - edge_t[15] == 5, "R11 chain gap asc+csc",
            edge_t[16] - edge_t[15], 5);
        chk(n_edges == 32, "R11 edges both frames", n_edges, 32);
        chk(int'(mosi[0]) == 16'h0096 && int'(mosi[1]) == 16'h0069, "R11 sent words",
            int'(mosi[1]), 16'h0069);
        chk(n_rxv == 2 && rx_got[0] == 16'h00F0 && rx_got[1] == 16'h0033,
            "R11 received words", int'(rx_got[1]), 16'h0033);

        // R12: hold requested but nothing waiting
        cfg_asc = 8'd3;
        @(negedge clk);
        arm();
        drive(16'h0011, 8, 1'b0, 1'b1);
        wait_accept();
        cmd_valid = 1'b0;
        wait_idle(1);
        chk(n_rise == 1 && rise_t[0] - edge_t[15] == 3, "R12 release after trail",
            rise_t[0] - edge_t[15], 3);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule